// File: doc/BRIEF.md
# Pending Interrupt Source Resolver

This block sits beside a banked interrupt controller that keeps three pending words: a top-level word and two secondary bank words. The top-level word mixes eight private sources, eleven shortcut bits that mirror selected secondary sources, and two summary bits that flag activity in each secondary bank. On a request, the resolver picks the single source that software should service next. It returns that source as one packed identifier, with the bank number in the upper bits and the bit number in the lower five bits.

The search is not a flat scan. Private bits are searched first, then the bank 1 shortcuts, then the bank 2 shortcuts, then the two summaries. A winning shortcut is mapped back to the real source number it mirrors. A winning summary is resolved by scanning that bank's own word. The result is registered, together with a one-cycle valid strobe. The pending words are sampled again on every request, so each answer reflects the state at the moment of the request.

Top module: `pend_resolver`

## Requirements
- R1: While reset is held and right after it, `valid_o` is 0 and `id_o` is the idle code 7'h7F.
- R2: Bits 31:21 of `top_pend_i` have no effect on the result.
- R3: If none of bits 20:0 of `top_pend_i` is set, a request returns the idle code 7'h7F.
- R4: If any of the private bits 7:0 is set, the result is the lowest set private bit with bank 0. The identifier is that bit number.
- R5: If the winner is a bank 1 shortcut (bits 14:10), its offset from bit 10 (0..4) selects source 7, 9, 10, 18 or 19. The identifier is 32 plus that source.
- R6: If the winner is a bank 2 shortcut (bits 15..20), its offset from bit 15 (0..5) selects source 21, 22, 23, 24, 25 or 30. The identifier is 64 plus that source.
- R7: The groups are served in this fixed order: private bits, bank 1 shortcuts, bank 2 shortcuts, bank 1 summary (bit 8), bank 2 summary (bit 9). Within a group, the lowest set bit wins.
- R8: If a summary bit wins, the result is bank × 32 plus the lowest set bit of that bank's pending word.
- R9: If a summary bit wins but its bank's pending word is zero, the result is the idle code.
- R10: `valid_o` is 1 in exactly the cycle after each cycle with `req_i` high, and 0 otherwise. `id_o` takes the result computed from the inputs at the request edge. It holds its value when there is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Resolve request, sampled each edge |
| top_pend_i | input | 32 | Top-level pending word |
| bank1_pend_i | input | 32 | Bank 1 pending word |
| bank2_pend_i | input | 32 | Bank 2 pending word |
| id_o | output | 7 | Packed identifier {bank, bit}, or 7'h7F when idle |
| valid_o | output | 1 | One-cycle strobe marking a fresh `id_o` |

## Verification
The functions that collide in one cycle are shortcut translation and summary resolution. A bank 1 source can show up both as a shortcut bit and as a set bit under the bank 1 summary. The bench provokes this by sweeping every pair of top-word bits while the bank words carry shifting patterns, some of them zero. For each pair, an arithmetic model built from the service order gives the expected identifier. A second collision is a new request arriving while the previous answer is still presented. Back-to-back requests with changing inputs check that each strobe carries the identifier for its own request.

// File: rtl/pend_pkg.sv
// Shared constants, identifier type and helpers for the pending resolver.
// Assumes the identifier is {bank[1:0], bit[4:0]}.
package pend_pkg;
    localparam int WORD_W   = 32;
    localparam int BIT_W    = 5;
    localparam int BANK_W   = 2;
    localparam int ID_W     = BANK_W + BIT_W;
    localparam int PRIV_N   = 8;
    localparam int SUM1_POS = 8;
    localparam int SUM2_POS = 9;
    localparam int SC1_LO   = 10;
    localparam int SC1_N    = 5;
    localparam int SC2_LO   = SC1_LO + SC1_N;
    localparam int SC2_N    = 6;
    localparam int USED_HI  = SC2_LO + SC2_N - 1;

    typedef logic [ID_W-1:0] src_id_t;
    localparam src_id_t IDLE_ID = '1;

    // Pack a bank number and a bit number into one identifier.
    function automatic src_id_t make_id(input logic [BANK_W-1:0] bank,
                                        input logic [BIT_W-1:0] bitn);
        return {bank, bitn};
    endfunction
endpackage

// File: rtl/pend_lowbit.sv
// Lowest-set-bit finder over an N-bit vector.
// Assumes N >= 2; idx is 0 when hit is low.
module pend_lowbit #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so that the lowest set bit is written last.
    always_comb begin
        hit = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/pend_sc_map.sv
// Maps a shortcut offset to the identifier of the real source it mirrors.
// BANK_SEL picks the table: 1 -> sources 7,9,10,18,19; 2 -> 21..25,30.
module pend_sc_map
    import pend_pkg::*;
#(
    parameter int BANK_SEL = 1,
    parameter int OFF_W    = 3
) (
    input  logic [OFF_W-1:0] off,
    output src_id_t          id
);
    logic [BIT_W-1:0] src;

    generate
        if (BANK_SEL == 1) begin : g_b1
            // Bank 1 table of mirrored source numbers.
            always_comb begin
                case (off)
                    OFF_W'(0): src = BIT_W'(7);
                    OFF_W'(1): src = BIT_W'(9);
                    OFF_W'(2): src = BIT_W'(10);
                    OFF_W'(3): src = BIT_W'(18);
                    OFF_W'(4): src = BIT_W'(19);
                    default:   src = '0;
                endcase
            end
        end else begin : g_b2
            // Bank 2 table of mirrored source numbers.
            always_comb begin
                case (off)
                    OFF_W'(0): src = BIT_W'(21);
                    OFF_W'(1): src = BIT_W'(22);
                    OFF_W'(2): src = BIT_W'(23);
                    OFF_W'(3): src = BIT_W'(24);
                    OFF_W'(4): src = BIT_W'(25);
                    OFF_W'(5): src = BIT_W'(30);
                    default:   src = '0;
                endcase
            end
        end
    endgenerate

    assign id = make_id(BANK_W'(BANK_SEL), src);
endmodule

// File: rtl/pend_resolver.sv
// Top: resolves the next pending source across three pending words.
// Order: private bits, bank 1 shortcuts, bank 2 shortcuts, bank 1 summary,
// bank 2 summary. Result is registered on req_i with a one-cycle strobe.
// Assumes the pending words are stable around the request edge.
module pend_resolver
    import pend_pkg::*;
#(
    parameter int PW    = WORD_W,
    parameter int OFF_W = 3,
    parameter int PIX_W = $clog2(PRIV_N),
    parameter int BIX_W = $clog2(PW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [PW-1:0] top_pend_i,
    input  logic [PW-1:0] bank1_pend_i,
    input  logic [PW-1:0] bank2_pend_i,
    output logic [ID_W-1:0] id_o,
    output logic          valid_o
);
    logic             priv_hit, sc1_hit, sc2_hit, b1_hit, b2_hit;
    logic [PIX_W-1:0] priv_idx;
    logic [OFF_W-1:0] sc1_off, sc2_off;
    logic [BIX_W-1:0] b1_idx, b2_idx;
    src_id_t          sc1_id, sc2_id, next_id, id_q;
    logic             vld_q;
    logic             unused_top;

    // Bits above the last shortcut take no part in resolution.
    assign unused_top = ^top_pend_i[PW-1:USED_HI+1];

    pend_lowbit #(.N(PRIV_N), .IDX_W(PIX_W)) u_priv (
        .vec(top_pend_i[PRIV_N-1:0]), .hit(priv_hit), .idx(priv_idx));
    pend_lowbit #(.N(SC1_N), .IDX_W(OFF_W)) u_sc1 (
        .vec(top_pend_i[SC1_LO +: SC1_N]), .hit(sc1_hit), .idx(sc1_off));
    pend_lowbit #(.N(SC2_N), .IDX_W(OFF_W)) u_sc2 (
        .vec(top_pend_i[SC2_LO +: SC2_N]), .hit(sc2_hit), .idx(sc2_off));
    pend_lowbit #(.N(PW), .IDX_W(BIX_W)) u_b1 (
        .vec(bank1_pend_i), .hit(b1_hit), .idx(b1_idx));
    pend_lowbit #(.N(PW), .IDX_W(BIX_W)) u_b2 (
        .vec(bank2_pend_i), .hit(b2_hit), .idx(b2_idx));

    pend_sc_map #(.BANK_SEL(1), .OFF_W(OFF_W)) u_map1 (.off(sc1_off), .id(sc1_id));
    pend_sc_map #(.BANK_SEL(2), .OFF_W(OFF_W)) u_map2 (.off(sc2_off), .id(sc2_id));

    // Fixed service order; an empty bank under a summary yields idle.
    always_comb begin
        next_id = IDLE_ID;
        if (priv_hit)
            next_id = make_id(BANK_W'(0), BIT_W'(priv_idx));
        else if (sc1_hit)
            next_id = sc1_id;
        else if (sc2_hit)
            next_id = sc2_id;
        else if (top_pend_i[SUM1_POS])
            next_id = b1_hit ? make_id(BANK_W'(1), BIT_W'(b1_idx)) : IDLE_ID;
        else if (top_pend_i[SUM2_POS])
            next_id = b2_hit ? make_id(BANK_W'(2), BIT_W'(b2_idx)) : IDLE_ID;
    end

    // Capture the result on request and raise the strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q  <= IDLE_ID;
            vld_q <= 1'b0;
        end else begin
            vld_q <= req_i;
            if (req_i) id_q <= next_id;
        end
    end

    assign id_o    = id_q;
    assign valid_o = vld_q;
endmodule

// File: rtl/pend_resolver_chk.sv
// Checker for pend_resolver, attached by bind. Relates the ports over time.
module pend_resolver_chk
    import pend_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic [WORD_W-1:0] top_pend_i,
    input logic [WORD_W-1:0] bank1_pend_i,
    input logic [ID_W-1:0]   id_o,
    input logic              valid_o
);
    a_r10_strobe_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);
    a_r10_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !valid_o);
    a_r10_id_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(id_o));
    a_r3_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && top_pend_i[USED_HI:0] == '0) |=> id_o == IDLE_ID);
    a_r4_private_bank0: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && |top_pend_i[PRIV_N-1:0]) |=> id_o[ID_W-1:BIT_W] == '0);
    a_r7_sc1_before_rest: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && top_pend_i[PRIV_N-1:0] == '0 && |top_pend_i[SC1_LO +: SC1_N])
        |=> id_o[ID_W-1:BIT_W] == BANK_W'(1));
    a_r9_empty_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && top_pend_i[USED_HI:0] == (1 << SUM1_POS) && bank1_pend_i == '0)
        |=> id_o == IDLE_ID);
endmodule

bind pend_resolver pend_resolver_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .top_pend_i(top_pend_i),
    .bank1_pend_i(bank1_pend_i), .id_o(id_o), .valid_o(valid_o));

// File: tb/pend_resolver_tb.sv
module pend_resolver_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [31:0] top_pend_i = '0, bank1_pend_i = '0, bank2_pend_i = '0;
    logic [6:0]  id_o;
    logic        valid_o;
    int total = 0, bad = 0;
    logic [31:0] lfsr = 32'hACE1_2468;

    always #10 clk = ~clk;

    pend_resolver u_dut (.clk(clk), .rst_n(rst_n), .req_i(req_i),
        .top_pend_i(top_pend_i), .bank1_pend_i(bank1_pend_i),
        .bank2_pend_i(bank2_pend_i), .id_o(id_o), .valid_o(valid_o));

    // Expected identifier from the service order in the requirements.
    function automatic logic [6:0] model(input logic [31:0] t, b1, b2);
        for (int i = 0; i < 8; i++) if (t[i]) return 7'(i);
        for (int i = 0; i < 5; i++) if (t[10+i]) begin
            case (i) 0: return 7'(32+7); 1: return 7'(32+9); 2: return 7'(32+10);
                     3: return 7'(32+18); default: return 7'(32+19); endcase
        end
        for (int i = 0; i < 6; i++) if (t[15+i]) begin
            if (i == 5) return 7'(64+30);
            return 7'(64 + 21 + i);
        end
        if (t[8]) begin
            for (int i = 0; i < 32; i++) if (b1[i]) return 7'(32+i);
            return 7'h7F;
        end
        if (t[9]) begin
            for (int i = 0; i < 32; i++) if (b2[i]) return 7'(64+i);
            return 7'h7F;
        end
        return 7'h7F;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] next_lfsr(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    // Drive one request at a falling edge, check the strobe and id after the next rising edge.
    task automatic resolve(input string tag, input logic [31:0] t, b1, b2);
        top_pend_i = t; bank1_pend_i = b1; bank2_pend_i = b2; req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        check({tag, " valid"}, 32'(valid_o), 32'd1);
        check(tag, 32'(id_o), 32'(model(t, b1, b2)));
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [6:0] held;
        repeat (3) @(negedge clk);
        check("R1 valid", 32'(valid_o), 32'd0);
        check("R1 id", 32'(id_o), 32'h7F);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after", 32'(id_o), 32'h7F);

        resolve("R3 empty", 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        resolve("R2 upper only", 32'hFFE0_0000, 32'h1, 32'h1);
        resolve("R2 upper plus sc2", 32'hFFF0_0000, 32'h1, 32'h1);

        // Single-bit sweep over every top bit, tagged by group.
        for (int i = 0; i < 32; i++) begin
            string tag;
            tag = (i < 8) ? "R4" : (i < 10) ? "R8" : (i < 15) ? "R5" : (i < 21) ? "R6" : "R2";
            lfsr = next_lfsr(lfsr);
            resolve(tag, 32'd1 << i, lfsr | 32'h8000_0000, ~lfsr | 32'h1000);
        end

        // Summary resolution over every lowest bank bit.
        for (int k = 0; k < 32; k++) begin
            resolve("R8 bank1", 32'h100, 32'hFFFF_FFFF << k, 32'h1);
            resolve("R8 bank2", 32'h200, 32'h1, 32'hFFFF_FFFF << k);
        end
        resolve("R9 bank1 empty", 32'h100, 32'h0, 32'hF);
        resolve("R9 bank2 empty", 32'h200, 32'hF, 32'h0);
        resolve("R9 both summaries, bank1 empty", 32'h300, 32'h0, 32'h4);

        // Pairwise sweep: shortcut and summary collisions and group order.
        for (int i = 0; i < 32; i++) begin
            for (int j = i; j < 32; j++) begin
                logic [31:0] b1, b2;
                lfsr = next_lfsr(lfsr); b1 = lfsr;
                lfsr = next_lfsr(lfsr); b2 = lfsr;
                if ((i + j) % 5 == 0) b1 = '0;
                if ((i + j) % 7 == 0) b2 = '0;
                resolve("R7 pair", (32'd1 << i) | (32'd1 << j), b1, b2);
            end
        end

        // Hold with no request: inputs change, id and strobe must not.
        resolve("R10 setup", 32'h400, 32'h0, 32'h0);
        held = id_o;
        top_pend_i = 32'h1; bank1_pend_i = 32'h2;
        repeat (2) @(negedge clk);
        check("R10 hold id", 32'(id_o), 32'(held));
        check("R10 no strobe", 32'(valid_o), 32'd0);

        // Back-to-back requests: each strobe carries its own answer.
        top_pend_i = 32'h8000; bank1_pend_i = 32'h0; bank2_pend_i = 32'h0; req_i = 1'b1;
        @(negedge clk);
        check("R10 b2b first", 32'(id_o), 32'(64+21));
        top_pend_i = 32'h4;
        @(negedge clk);
        req_i = 1'b0;
        check("R10 b2b second", 32'(id_o), 32'd2);
        check("R10 b2b valid", 32'(valid_o), 32'd1);
        @(negedge clk);
        check("R10 strobe drop", 32'(valid_o), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule